// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that advances either on an internal cycle tick (the system clock divided by four) or on edges of an external input pin, with a programmable choice of rising or falling edge. The pin goes through a two-flop synchronizer and an edge detector before it can advance anything. A single power-of-two prescaler sits in the path and is assigned by one option bit either to this counter or to the watchdog tick path, never both at once. Software loads the count, the option bits and the control bits through a simple write port. Their current values are always visible on output pins.

When the count wraps from 0xFF to 0x00 the block sets an overflow flag, and it raises an interrupt request when both enables are on. When the prescaler is given to the watchdog, the block divides the incoming watchdog ticks by the selected rate and passes them out. The counter then advances once per selected event with no division. The watchdog's own timeout logic is not part of the block.

Top module: `tmr8_timer`

## Requirements
- R1: After reset the count is 0x00, the option bits are all ones (6'h3F) and the control bits (flag, timer enable, global enable) are all 0.
- R2: A write with wr_sel_i=0 loads wr_data_i into the count on that clock edge and restarts both the divide-by-four cycle divider and the prescaler. With the internal source (option bit 5 = 0) and the prescaler on the watchdog (option bit 3 = 1), the count then rises by one every 4 clocks, first 4 clocks after the load.
- R3: With the prescaler on the counter (option bit 3 = 0) and rate code c in option bits 2:0, the counter advances once per 2^(c+1) source events, from 1:2 for code 0 to 1:256 for code 7.
- R4: With the external source (option bit 5 = 1), option bit 4 = 0 counts rising pin edges and option bit 4 = 1 counts falling pin edges; the other edge has no effect. A pin edge shows on the count at the third rising clock edge after it.
- R5: With option bit 3 = 1, wdt_tick_o pulses once per 2^c wdt_tick_i pulses (1:1 for code 0 up to 1:128 for code 7). With option bit 3 = 0, wdt_tick_o stays 0 and wdt_tick_i has no effect on the count.
- R6: A write with wr_sel_i=1 loads wr_data_i[5:0] into the option bits: bit 5 source, bit 4 edge, bit 3 prescaler assignment, bits 2:0 rate.
- R7: An advance from 0xFF wraps the count to 0x00 and sets the flag (control bit 0), which stays set until software writes 0 to it with wr_sel_i=2.
- R8: irq_o is high exactly when the flag, the timer enable (control bit 1) and the global enable (control bit 2) are all 1.
- R9: When an overflow and a control write land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| wdt_tick_i | input | 1 | Watchdog base tick, one cycle per pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 option, 2 control |
| wr_data_i | input | 8 | Write data |
| count_o | output | 8 | Current count |
| option_o | output | 6 | Option bits {source, edge, assign, rate[2:0]} |
| ctrl_o | output | 3 | Control bits {global enable, timer enable, flag} |
| irq_o | output | 1 | Interrupt request |
| wdt_tick_o | output | 1 | Prescaled watchdog tick |

## Verification
The assertions assume that wr_sel_i never takes the unused value 3 while wr_en_i is high, and that wdt_tick_i is a clean single-cycle pulse on the system clock. They also assume that the external pin is held at each level for at least two clocks, so that the synchronizer sees every level and no edge is lost. The stimulus only drives legal selects, pulses wdt_tick_i for one cycle at a time, and holds each pin level for three or more clocks. Random trials keep to the internal source, where the event rate follows from the clock count alone.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_COUNT  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OPTION = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd2;

  typedef struct packed {
    logic              ext_src;
    logic              fall_edge;
    logic              to_wdt;
    logic [RATE_W-1:0] rate;
  } option_t;

  typedef struct packed {
    logic glb_en;
    logic tmr_en;
    logic flag;
  } ctrl_t;
endpackage

// File: rtl/tmr8_edge_det.sv
module tmr8_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic hit_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  logic cur, prev;
  assign cur  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign hit_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              ev_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              to_wdt_i,
  output logic              tick_o
);
  localparam int unsigned DIV_W = $clog2(PRE_W + 1);

  logic [PRE_W-1:0] cnt_q;
  logic [DIV_W-1:0] div;
  logic [PRE_W-1:0] mask;

  // counter use divides one step more than watchdog use for the same code
  assign div  = to_wdt_i ? DIV_W'(rate_i) : DIV_W'(rate_i) + DIV_W'(1);
  assign mask = ~({PRE_W{1'b1}} << div);
  assign tick_o = ev_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (ev_i)    cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int unsigned CYC_LOG2  = 2,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_i,
  input  logic              wdt_tick_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [5:0]        option_o,
  output logic [2:0]        ctrl_o,
  output logic              irq_o,
  output logic              wdt_tick_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  option_t              opt_q;
  ctrl_t                ctl_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CYC_LOG2-1:0]  phase_q;

  logic wr_cnt, wr_opt, wr_ctl;
  assign wr_cnt = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign wr_opt = wr_en_i && (wr_sel_i == SEL_OPTION);
  assign wr_ctl = wr_en_i && (wr_sel_i == SEL_CTRL);

  // instruction-cycle tick: system clock divided by 2**CYC_LOG2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (wr_cnt) phase_q <= '0;
    else             phase_q <= phase_q + CYC_LOG2'(1);
  end

  logic cyc_tick;
  assign cyc_tick = &phase_q;

  logic pin_hit;
  tmr8_edge_det #(.STAGES(SYNC_STGS)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin_i),
    .fall_sel_i (opt_q.fall_edge),
    .hit_o      (pin_hit)
  );

  logic src_ev, pre_in, pre_tick, inc;
  assign src_ev = opt_q.ext_src ? pin_hit : cyc_tick;
  assign pre_in = opt_q.to_wdt ? wdt_tick_i : src_ev;

  tmr8_prescaler #(.PRE_W(CNT_W), .RATE_W(RATE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (wr_cnt),
    .ev_i     (pre_in),
    .rate_i   (opt_q.rate),
    .to_wdt_i (opt_q.to_wdt),
    .tick_o   (pre_tick)
  );

  assign inc        = opt_q.to_wdt ? src_ev : pre_tick;
  assign wdt_tick_o = opt_q.to_wdt & pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data_i;
    else if (inc)    cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opt_q <= '1;
    else if (wr_opt) opt_q <= option_t'(wr_data_i[5:0]);
  end

  logic ovf;
  assign ovf = inc && !wr_cnt && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.glb_en <= wr_data_i[2];
        ctl_q.tmr_en <= wr_data_i[1];
      end
      if (ovf)         ctl_q.flag <= 1'b1;
      else if (wr_ctl) ctl_q.flag <= wr_data_i[0];
    end
  end

  assign count_o  = cnt_q;
  assign option_o = opt_q;
  assign ctrl_o   = ctl_q;
  assign irq_o    = ctl_q.flag & ctl_q.tmr_en & ctl_q.glb_en;
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] count_o,
  input logic [5:0] option_o,
  input logic [2:0] ctrl_o,
  input logic       irq_o,
  input logic       wdt_tick_o
);
  logic wr_cnt, wr_ctl;
  assign wr_cnt = wr_en_i && (wr_sel_i == 2'd0);
  assign wr_ctl = wr_en_i && (wr_sel_i == 2'd2);

  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_o == $past(wr_data_i))); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (count_o == $past(count_o) || count_o == $past(count_o) + 8'd1)); // R3

  AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !option_o[3] |-> !wdt_tick_o); // R5

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && count_o == 8'hFF) ##1 (count_o == 8'h00) |-> ctrl_o[0]); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] && !wr_ctl) |=> ctrl_o[0]); // R7

  AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl_o == 3'b111)); // R8

  AST_IRQ_WHEN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o == 3'b111) |-> irq_o); // R8
endmodule

bind tmr8_timer tmr8_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .option_o   (option_o),
  .ctrl_o     (ctrl_o),
  .irq_o      (irq_o),
  .wdt_tick_o (wdt_tick_o)
);

// File: tb/tmr8_timer_bench.sv
module tmr8_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [7:0] count_o;
  logic [5:0] option_o;
  logic [2:0] ctrl_o;
  logic       irq_o;
  logic       wdt_tick_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmr8_timer u_tmr8_timer (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .wdt_tick_i(wdt_tick_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .count_o(count_o), .option_o(option_o), .ctrl_o(ctrl_o),
    .irq_o(irq_o), .wdt_tick_o(wdt_tick_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_steps(input int n, input bit to_wdt, input int rate);
    int per = to_wdt ? 4 : 4 * (2 << rate);
    return n / per;
  endfunction

  function automatic bit exp_irq(input bit flag, input logic [2:0] en);
    return flag && en[1] && en[2];
  endfunction

  initial begin
    automatic int seed = 32'h5EED_1234;
    void'($urandom(seed));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 count", count_o, 0);
    check("R1 option", option_o, 6'h3F);
    check("R1 ctrl", ctrl_o, 0);

    // R6 option load and R2 internal count, prescaler on watchdog
    wr(2'd1, 8'b00_0_0_1_010);
    check("R6 option", option_o, 6'b001010);
    wr(2'd0, 8'h10);
    idle(3);
    check("R2 before first tick", count_o, 8'h10);
    idle(1);
    check("R2 first tick", count_o, 8'h11);
    idle(36);
    check("R2 40 clocks", count_o, 8'h10 + 10);

    // R3 prescaler on counter, code 1 -> 1:4
    wr(2'd1, 8'b00_0_0_0_001);
    wr(2'd0, 8'h00);
    idle(15);
    check("R3 1:4 before", count_o, 0);
    idle(1);
    check("R3 1:4 at 16", count_o, 1);

    // R7 wrap sets flag, R8 irq
    wr(2'd1, 8'b00_0_0_1_000);
    wr(2'd0, 8'hFC);
    wr(2'd2, 8'b110);
    idle(19);
    check("R7 wrap count", count_o, 8'h01);
    check("R7 flag set", ctrl_o[0], 1);
    check("R8 irq on", irq_o, 1);
    idle(20);
    check("R7 flag held", ctrl_o[0], 1);
    wr(2'd2, 8'b010);
    check("R7 flag cleared", ctrl_o[0], 0);
    check("R8 irq off gie 0", irq_o, 0);

    // R9 overflow and clear on the same edge
    wr(2'd0, 8'hFF);
    idle(3);
    wr(2'd2, 8'b110);
    check("R9 count wrapped", count_o, 0);
    check("R9 flag wins", ctrl_o[0], 1);
    wr(2'd2, 8'b000);
    check("R9 flag then cleared", ctrl_o[0], 0);

    // R4 external, falling edge select
    wr(2'd1, 8'b00_1_1_1_000);
    wr(2'd0, 8'h00);
    ext_pin_i = 1'b1;
    idle(5);
    check("R4 rising ignored", count_o, 0);
    ext_pin_i = 1'b0;
    idle(2);
    check("R4 latency 2", count_o, 0);
    idle(1);
    check("R4 falling counted", count_o, 1);
    // rising edge select, five pulses
    wr(2'd1, 8'b00_1_0_1_000);
    wr(2'd0, 8'h00);
    for (int p = 0; p < 5; p++) begin
      ext_pin_i = 1'b1; idle(3);
      ext_pin_i = 1'b0; idle(3);
    end
    idle(3);
    check("R4 rising pulses", count_o, 5);
    // external with prescaler 1:2
    wr(2'd1, 8'b00_1_0_0_000);
    wr(2'd0, 8'h00);
    for (int p = 0; p < 7; p++) begin
      ext_pin_i = 1'b1; idle(3);
      ext_pin_i = 1'b0; idle(3);
    end
    idle(3);
    check("R3 external 1:2", count_o, 3);

    // R5 watchdog path, code 3 -> 1:8
    begin
      automatic int seen = 0;
      wr(2'd1, 8'b00_1_0_1_011);
      wr(2'd0, 8'h00);
      for (int p = 0; p < 40; p++) begin
        wdt_tick_i = 1'b1;
        @(posedge clk); #1;
        if (wdt_tick_o) seen++;
        @(negedge clk);
        wdt_tick_i = 1'b0;
        idle(1);
      end
      check("R5 wdt 1:8", seen, 5);
      seen = 0;
      wr(2'd1, 8'b00_1_0_0_000);
      wr(2'd0, 8'h33);
      for (int p = 0; p < 20; p++) begin
        wdt_tick_i = 1'b1;
        @(posedge clk); #1;
        if (wdt_tick_o) seen++;
        @(negedge clk);
        wdt_tick_i = 1'b0;
      end
      check("R5 wdt off", seen, 0);
      check("R5 count untouched", count_o, 8'h33);
    end

    // random trials, internal source
    for (int t = 0; t < 30; t++) begin
      automatic bit         tw   = 1'($urandom_range(0, 1));
      automatic int         rate = $urandom_range(0, 7);
      automatic int         v    = $urandom_range(0, 255);
      automatic int         n    = $urandom_range(2, 1500);
      automatic logic [2:0] en   = 3'($urandom_range(0, 3)) << 1;
      automatic int         tot;
      wr(2'd1, {2'b00, 1'b0, 1'b0, tw, 3'(rate)});
      wr(2'd0, 8'(v));
      wr(2'd2, {5'b0, en});
      idle(n - 1);
      tot = v + exp_steps(n, tw, rate);
      check(tw ? "R2 random count" : "R3 random count", count_o, tot % 256);
      check("R7 random flag", ctrl_o[0], tot > 255);
      check("R8 random irq", irq_o, exp_irq(tot > 255, en));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule